// File: doc/BRIEF.md
# Spiking-Network Training Pipeline Issue Scheduler

This block issues the per-cycle control for a layered spiking-network training engine that overlaps work at three levels: the timesteps of one sample, the samples of one batch, and consecutive batches. It takes a sample-valid handshake and a configuration of timestep count, batch size and active layer count. It drives one-cycle-granular enables for every layer's forward stage, a single output-error strobe, the per-layer error projection, gradient accumulation and weight update enables, activation-buffer allocate and release commands, a batch-done pulse and the index of the weight copy that forward passes read.

Hidden-layer errors come from a fixed random projection of the output error. They therefore depend neither on deeper layers nor on the timestep. For this reason, projection and gradient work for all layers run in the same cycles, and one projection per sample serves all of its timesteps. Each admitted sample holds one entry of a uniform pool that is released in allocation order. When the pool is full, the handshake stalls.

Top module: `snnTrainSched`

## Requirements
- R1: While reset is held, sampleReady is 1 and every enable, strobe and pulse output is 0; weightBank is 0.
- R2: A sample is admitted in a cycle where sampleValid and sampleReady are both 1. While a sample is still in its forward timesteps, sampleReady is 0, except in that sample's final timestep. Admissions are therefore at least T cycles apart.
- R3: Let s be the cycle after admission. Bit l of fwdEn (bit 0 = first layer) is 1 in cycles s+l through s+l+T-1 for every layer l below the configured layer count L. Bits at or above L stay 0.
- R4: errOutEn pulses once per sample in cycle s+L-1+T. In cycle s+L+T, projEn pulses once for all L configured layers together.
- R5: gradEn is 1 for all L configured layers together during the T cycles s+L+T+1 through s+L+2T, with no wait between layers.
- R6: bufAlloc is 1 in the admission cycle, with bufAllocIdx counting 0,1,..,DEPTH-1 and wrapping. bufRelease pulses in cycle s+L+2T. bufReleaseIdx follows the same order as allocation.
- R7: With all DEPTH entries in use, sampleReady is 0 and the held sample waits. Every admitted sample is later released.
- R8: One cycle after the release of the last sample of a batch (the cfgBatch-th admitted), updEn is 1 for all L configured layers for one cycle. This may overlap forward work of the next batch.
- R9: batchDone pulses in the cycle after updEn. weightBank toggles in the cycle after batchDone and changes at no other time.
- R10: Configuration inputs are captured only when the block is idle (no sample in forward, no pool entry in use, no update or done pending). Changes while busy have no effect on the run in progress.
- R11: A synchronous reset in mid-run clears all activity, counters and pool pointers. The next allocation index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgSteps | input | TW | Timesteps per sample T (1..MAX_T) |
| cfgBatch | input | BW | Samples per batch (1..MAX_BATCH) |
| cfgLayers | input | LW | Active layer count L (1..LAYERS) |
| sampleValid | input | 1 | A new sample is offered |
| sampleReady | output | 1 | Sample can be admitted this cycle |
| fwdEn | output | LAYERS | Per-layer forward enable |
| errOutEn | output | 1 | Output-error computation strobe |
| projEn | output | LAYERS | Per-layer error projection strobe |
| gradEn | output | LAYERS | Per-layer gradient accumulate enable |
| updEn | output | LAYERS | Per-layer weight update strobe |
| bufAlloc | output | 1 | Allocate an activation buffer entry |
| bufAllocIdx | output | PW | Index of entry being allocated |
| bufRelease | output | 1 | Release the oldest entry |
| bufReleaseIdx | output | PW | Index of entry being released |
| batchDone | output | 1 | Pulse one cycle after the batch's weight write |
| weightBank | output | 1 | Weight copy read by forward passes |

## Verification
The situation hardest to reach from the ports is a full pool at the same time as a release and the batch update overlapping forward work of the next batch. The readiness decision then depends on releases that trail admissions by L+2T cycles. The bench reaches it by sweeping small configurations with single-timestep, four-layer setups and back-to-back valid, where more samples are in flight than the pool holds. Gapped valid patterns exercise the non-stalled path. The bench changes the configuration inputs immediately after the first admission of every run and applies a reset mid-stream. It predicts every output cycle by cycle from its own list of admission times.

// File: rtl/snnSchedPkg.sv
package snnSchedPkg;
  // Per-cycle strobe bundle from admission control to the stage timer.
  typedef struct packed {
    logic active;     // a sample occupies the first layer this cycle
    logic stepLast;   // this is that sample's final timestep
    logic batchLast;  // that sample closes its batch
  } issueT;
endpackage

// File: rtl/schedCtrl.sv
module schedCtrl
  import snnSchedPkg::*;
#(
  parameter int MAX_T     = 8,
  parameter int MAX_BATCH = 8,
  parameter int LAYERS    = 4,
  localparam int TW = $clog2(MAX_T + 1),
  localparam int BW = $clog2(MAX_BATCH + 1),
  localparam int LW = $clog2(LAYERS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [TW-1:0] cfgSteps,
  input  logic [BW-1:0] cfgBatch,
  input  logic [LW-1:0] cfgLayers,
  input  logic          sampleValid,
  input  logic          bufFull,
  input  logic          bufEmpty,
  input  logic          stageBusy,
  output logic          sampleReady,
  output logic          sampleFire,
  output logic [TW-1:0] stepsReg,
  output logic [LW-1:0] layersReg,
  output issueT         issue
);
  logic          fwdActive;
  logic [TW-1:0] tsCnt;
  logic [BW-1:0] batchReg;
  logic [BW-1:0] sampCnt;
  logic          batchLastReg;
  logic          stepLast;
  logic          idleNow;
  logic          cfgLoad;
  logic          closesBatch;

  assign stepLast    = fwdActive && (tsCnt == stepsReg - TW'(1));
  assign sampleReady = !bufFull && (!fwdActive || stepLast);
  assign sampleFire  = sampleValid && sampleReady;
  assign idleNow     = !fwdActive && bufEmpty && !stageBusy;
  assign cfgLoad     = idleNow && !sampleFire;
  assign closesBatch = (sampCnt == batchReg - BW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepsReg     <= TW'(1);
      batchReg     <= BW'(1);
      layersReg    <= LW'(LAYERS);
      fwdActive    <= 1'b0;
      tsCnt        <= '0;
      sampCnt      <= '0;
      batchLastReg <= 1'b0;
    end else begin
      if (cfgLoad) begin
        stepsReg  <= cfgSteps;
        batchReg  <= cfgBatch;
        layersReg <= cfgLayers;
      end
      if (sampleFire) begin
        fwdActive    <= 1'b1;
        tsCnt        <= '0;
        batchLastReg <= closesBatch;
        sampCnt      <= closesBatch ? '0 : sampCnt + BW'(1);
      end else if (fwdActive) begin
        if (stepLast) fwdActive <= 1'b0;
        else          tsCnt     <= tsCnt + TW'(1);
      end
    end
  end

  assign issue = {fwdActive, stepLast, batchLastReg};

  // Multi-timestep samples block the next admission in the following cycle.
  assert_ready_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleFire && stepsReg != TW'(1)) |=> !sampleReady);

  // Configuration registers hold while anything is in flight.
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !idleNow |=> ($stable(stepsReg) && $stable(batchReg) && $stable(layersReg)));
endmodule

// File: rtl/bufPool.sv
module bufPool #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          alloc,
  input  logic          release_,
  output logic [PW-1:0] allocIdx,
  output logic [PW-1:0] relIdx,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [CW-1:0] inUse;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      inUse <= '0;
    end else begin
      if (alloc)    wrPtr <= bump(wrPtr);
      if (release_) rdPtr <= bump(rdPtr);
      inUse <= inUse + CW'(alloc) - CW'(release_);
    end
  end

  assign allocIdx = wrPtr;
  assign relIdx   = rdPtr;
  assign full     = (inUse == CW'(DEPTH));
  assign empty    = (inUse == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    alloc |-> !full);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    release_ |-> !empty);
endmodule

// File: rtl/stageTimer.sv
module stageTimer
  import snnSchedPkg::*;
#(
  parameter int MAX_T  = 8,
  parameter int LAYERS = 4,
  localparam int TW = $clog2(MAX_T + 1),
  localparam int LW = $clog2(LAYERS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TW-1:0]     stepsReg,
  input  logic [LW-1:0]     layersReg,
  input  issueT             issue,
  output logic [LAYERS-1:0] fwdEn,
  output logic              errOutEn,
  output logic [LAYERS-1:0] projEn,
  output logic [LAYERS-1:0] gradEn,
  output logic [LAYERS-1:0] updEn,
  output logic              relStrobe,
  output logic              batchDone,
  output logic              weightBank,
  output logic              busy
);
  logic [LAYERS-1:0] tapVld, tapLst, tapBl, layerMask;
  logic              tailLast, tailBl;
  logic              errBl, projPulse, projBl;
  logic              gradActive, gradBl;
  logic [TW-1:0]     gradCnt;
  logic              updPulse, doneReg, bankReg;

  assign tapVld[0] = issue.active;
  assign tapLst[0] = issue.stepLast;
  assign tapBl[0]  = issue.batchLast;

  // Forward wavefront: each deeper layer trails its predecessor by one cycle.
  for (genvar l = 1; l < LAYERS; l++) begin : g_wave
    logic stVld, stLst, stBl;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stVld <= 1'b0;
        stLst <= 1'b0;
        stBl  <= 1'b0;
      end else begin
        stVld <= tapVld[l-1];
        stLst <= tapLst[l-1];
        stBl  <= tapBl[l-1];
      end
    end
    assign tapVld[l] = stVld;
    assign tapLst[l] = stLst;
    assign tapBl[l]  = stBl;
  end

  for (genvar l = 0; l < LAYERS; l++) begin : g_mask
    assign layerMask[l] = (LW'(l) < layersReg);
  end

  always_comb begin
    tailLast = 1'b0;
    tailBl   = 1'b0;
    for (int l = 0; l < LAYERS; l++) begin
      if (LW'(l + 1) == layersReg) begin
        tailLast = tapVld[l] && tapLst[l];
        tailBl   = tapBl[l];
      end
    end
  end

  assign relStrobe = gradActive && (gradCnt == stepsReg - TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errOutEn   <= 1'b0;
      errBl      <= 1'b0;
      projPulse  <= 1'b0;
      projBl     <= 1'b0;
      gradActive <= 1'b0;
      gradCnt    <= '0;
      gradBl     <= 1'b0;
      updPulse   <= 1'b0;
      doneReg    <= 1'b0;
      bankReg    <= 1'b0;
    end else begin
      errOutEn  <= tailLast;
      errBl     <= tailBl;
      projPulse <= errOutEn;
      projBl    <= errBl;
      if (projPulse) begin
        gradActive <= 1'b1;
        gradCnt    <= '0;
        gradBl     <= projBl;
      end else if (relStrobe) begin
        gradActive <= 1'b0;
      end else if (gradActive) begin
        gradCnt <= gradCnt + TW'(1);
      end
      updPulse <= relStrobe && gradBl;
      doneReg  <= updPulse;
      if (doneReg) bankReg <= ~bankReg;
    end
  end

  assign fwdEn      = tapVld & layerMask;
  assign projEn     = {LAYERS{projPulse}} & layerMask;
  assign gradEn     = {LAYERS{gradActive}} & layerMask;
  assign updEn      = {LAYERS{updPulse}} & layerMask;
  assign batchDone  = doneReg;
  assign weightBank = bankReg;
  assign busy       = updPulse || doneReg;

  // A gradient window runs its full T cycles once started.
  assert_grad_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gradActive && gradCnt != stepsReg - TW'(1)) |=> gradActive);

  // The forward weight copy swaps only right after a batch completes.
  assert_bank_swap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (bankReg != $past(bankReg)) |-> $past(doneReg));
endmodule

// File: rtl/snnTrainSched.sv
module snnTrainSched
  import snnSchedPkg::*;
#(
  parameter int MAX_T     = 8,
  parameter int MAX_BATCH = 8,
  parameter int LAYERS    = 4,
  parameter int DEPTH     = 4,
  localparam int TW = $clog2(MAX_T + 1),
  localparam int BW = $clog2(MAX_BATCH + 1),
  localparam int LW = $clog2(LAYERS + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TW-1:0]     cfgSteps,
  input  logic [BW-1:0]     cfgBatch,
  input  logic [LW-1:0]     cfgLayers,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic [LAYERS-1:0] fwdEn,
  output logic              errOutEn,
  output logic [LAYERS-1:0] projEn,
  output logic [LAYERS-1:0] gradEn,
  output logic [LAYERS-1:0] updEn,
  output logic              bufAlloc,
  output logic [PW-1:0]     bufAllocIdx,
  output logic              bufRelease,
  output logic [PW-1:0]     bufReleaseIdx,
  output logic              batchDone,
  output logic              weightBank
);
  issueT         issue;
  logic [TW-1:0] stepsReg;
  logic [LW-1:0] layersReg;
  logic          bufFull, bufEmpty, stageBusy;

  schedCtrl #(.MAX_T(MAX_T), .MAX_BATCH(MAX_BATCH), .LAYERS(LAYERS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgSteps(cfgSteps), .cfgBatch(cfgBatch), .cfgLayers(cfgLayers),
    .sampleValid(sampleValid), .bufFull(bufFull), .bufEmpty(bufEmpty),
    .stageBusy(stageBusy), .sampleReady(sampleReady), .sampleFire(bufAlloc),
    .stepsReg(stepsReg), .layersReg(layersReg), .issue(issue)
  );

  bufPool #(.DEPTH(DEPTH)) pool_i (
    .clk(clk), .rstN(rstN), .alloc(bufAlloc), .release_(bufRelease),
    .allocIdx(bufAllocIdx), .relIdx(bufReleaseIdx),
    .full(bufFull), .empty(bufEmpty)
  );

  stageTimer #(.MAX_T(MAX_T), .LAYERS(LAYERS)) timer_i (
    .clk(clk), .rstN(rstN), .stepsReg(stepsReg), .layersReg(layersReg),
    .issue(issue), .fwdEn(fwdEn), .errOutEn(errOutEn), .projEn(projEn),
    .gradEn(gradEn), .updEn(updEn), .relStrobe(bufRelease),
    .batchDone(batchDone), .weightBank(weightBank), .busy(stageBusy)
  );
endmodule

// File: tb/snnTrainSched_tb_top.sv
module snnTrainSched_tb_top;
  localparam int NL = 4;
  localparam int DEPTH = 4;
  localparam int TW = 4, BW = 4, LW = 3, PW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TW-1:0] cfgSteps = TW'(1);
  logic [BW-1:0] cfgBatch = BW'(1);
  logic [LW-1:0] cfgLayers = LW'(1);
  logic sampleValid = 1'b0;
  logic sampleReady, errOutEn, bufAlloc, bufRelease, batchDone, weightBank;
  logic [NL-1:0] fwdEn, projEn, gradEn, updEn;
  logic [PW-1:0] bufAllocIdx, bufReleaseIdx;

  snnTrainSched #(.MAX_T(8), .MAX_BATCH(8), .LAYERS(NL), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .cfgSteps(cfgSteps), .cfgBatch(cfgBatch),
    .cfgLayers(cfgLayers), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .fwdEn(fwdEn), .errOutEn(errOutEn), .projEn(projEn), .gradEn(gradEn),
    .updEn(updEn), .bufAlloc(bufAlloc), .bufAllocIdx(bufAllocIdx),
    .bufRelease(bufRelease), .bufReleaseIdx(bufReleaseIdx),
    .batchDone(batchDone), .weightBank(weightBank)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int admA[1024], admT[1024], admL[1024], admBl[1024];
  int nAdm = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Predict every output for the current cycle from the admission list.
  task automatic checkNow(input logic vIn, output logic fireE);
    int c, eFwd, eErr, eProj, eGrad, eUpd, eRel, eRelIdx, eDone, bankCnt, inUse;
    logic busy, eReady;
    c = cyc; eFwd = 0; eErr = 0; eProj = 0; eGrad = 0; eUpd = 0; eRel = 0;
    eRelIdx = 0; eDone = 0; bankCnt = 0; inUse = 0; busy = 1'b0;
    for (int i = 0; i < nAdm; i++) begin
      int s, t, l, all;
      s = admA[i] + 1; t = admT[i]; l = admL[i]; all = (1 << l) - 1;
      for (int k = 0; k < l; k++)
        if (c >= s + k && c <= s + k + t - 1) eFwd |= (1 << k);
      if (c == s + l - 1 + t) eErr = 1;
      if (c == s + l + t) eProj = all;
      if (c >= s + l + t + 1 && c <= s + l + 2*t) eGrad = all;
      if (c == s + l + 2*t) begin eRel = 1; eRelIdx = i % DEPTH; end
      if (admBl[i] != 0) begin
        if (c == s + l + 2*t + 1) eUpd = all;
        if (c == s + l + 2*t + 2) eDone = 1;
        if (s + l + 2*t + 2 <= c - 1) bankCnt++;
      end
      if (c >= s && c <= s + t - 2) busy = 1'b1;
      if (admA[i] <= c - 1) inUse++;
      if (s + l + 2*t <= c - 1) inUse--;
    end
    eReady = !busy && (inUse < DEPTH);
    fireE = vIn && eReady;
    chk("R2 R7 ready", int'(sampleReady), int'(eReady));
    chk("R3 R10 fwdEn", int'(fwdEn), eFwd);
    chk("R4 errOutEn", int'(errOutEn), eErr);
    chk("R4 projEn", int'(projEn), eProj);
    chk("R5 gradEn", int'(gradEn), eGrad);
    chk("R6 bufAlloc", int'(bufAlloc), int'(fireE));
    if (fireE) chk("R6 bufAllocIdx", int'(bufAllocIdx), nAdm % DEPTH);
    chk("R6 bufRelease", int'(bufRelease), eRel);
    if (eRel != 0) chk("R6 bufReleaseIdx", int'(bufReleaseIdx), eRelIdx);
    chk("R8 updEn", int'(updEn), eUpd);
    chk("R9 batchDone", int'(batchDone), eDone);
    chk("R9 weightBank", int'(weightBank), bankCnt % 2);
  endtask

  task automatic tick(input logic v, output logic fired);
    @(posedge clk);
    cyc++;
    #1 sampleValid = v;
    #2 checkNow(v, fired);
  endtask

  task automatic doRun(input int t, input int l, input int b, input int gap, input int abortAt);
    int left, g, idx, n;
    logic f;
    left = 2*b; g = 0; idx = 0; n = 0;
    cfgSteps = TW'(t); cfgBatch = BW'(b); cfgLayers = LW'(l);
    tick(1'b0, f);
    tick(1'b0, f);
    while (left > 0 && n < 2000) begin
      tick(g == 0, f);
      if (f) begin
        admA[nAdm] = cyc; admT[nAdm] = t; admL[nAdm] = l;
        admBl[nAdm] = ((idx % b) == b - 1) ? 1 : 0;
        nAdm++; idx++; left--; g = gap;
        if (idx == 1) begin
          // R10: configuration edits while busy must not alter this run
          cfgSteps = TW'((t == 3) ? 1 : 3);
          cfgBatch = BW'((b == 3) ? 1 : 3);
          cfgLayers = LW'((l == 4) ? 1 : 4);
        end
      end else if (g > 0) begin
        g--;
      end
      n++;
      if (abortAt > 0 && n >= abortAt) return;
    end
    if (n >= 2000) chk("R7 stream stalled", 0, 1);
    repeat (l + 2*t + 6) tick(1'b0, f);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic f;
    repeat (2) @(posedge clk);
    #3;
    // R1: reset state
    chk("R1 ready", int'(sampleReady), 1);
    chk("R1 fwdEn", int'(fwdEn), 0);
    chk("R1 pulses", int'({errOutEn, projEn, gradEn, updEn, bufRelease, batchDone}), 0);
    chk("R1 weightBank", int'(weightBank), 0);
    rstN = 1'b1;

    for (int g = 0; g <= 2; g += 2)
      for (int t = 1; t <= 3; t++)
        for (int li = 0; li < 3; li++)
          for (int b = 1; b <= 3; b++)
            doRun(t, (li == 2) ? 4 : li + 1, b, g, 0);

    // R11: synchronous reset in the middle of a stream
    doRun(2, 4, 2, 0, 6);
    @(posedge clk); cyc++;
    #1 sampleValid = 1'b0; rstN = 1'b0;
    #2 checkNow(1'b0, f);
    @(posedge clk); cyc++;
    #1 rstN = 1'b1; nAdm = 0;
    #2;
    chk("R11 ready", int'(sampleReady), 1);
    chk("R11 enables", int'({fwdEn, projEn, gradEn, updEn}), 0);
    chk("R11 pulses", int'({errOutEn, bufAlloc, bufRelease, batchDone}), 0);
    chk("R11 weightBank", int'(weightBank), 0);
    doRun(1, 2, 1, 0, 0);
    doRun(1, 4, 2, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule